// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master with a small bank of 32-bit registers on a simple single-cycle write / combinational read bus. Software picks the clock polarity, clock phase, word size (8 or 16 bits) and the bit order. Transmit and receive bit order are set separately. Software also picks one of eight active-low chip selects and whether that select is asserted. A write to the transmit register starts one full-duplex word on SCLK/MOSI/MISO. When the last bit has been captured, the received word appears in the receive register and a completion flag sets in the cause register. Software clears the flag by writing the cause register.

SCLK timing comes from an external enable, `sclk_tick`. Each tick during a transfer produces one SCLK edge. A word of N bits therefore takes 2N ticks. MISO is not captured on the sampling edge itself. It is captured a programmable number of system clocks later, so that slow slave output paths at high SCLK rates can still be read.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, all chip selects are high and SCLK is low. Reads return 0 from control (0x00), configuration (0x04), cause (0x10) and receive (0x0C), and 0x40 from timing (0x18), because the sample delay resets to 1.
- R2: Control bit 0 set with index k in control bits [4:2] drives only `spi_cs_n[k]` low. With bit 0 clear, all eight selects are high.
- R3: A write to 0x08 while idle starts a transfer of 8 bits, or of 16 bits when configuration bit 5 is set. The transfer makes exactly 2N SCLK edges, one per tick. Ticks while idle produce no edge.
- R4: SCLK rests at configuration bit 11 (CPOL) while idle. With configuration bit 12 (CPHA) clear, MOSI is valid before the first edge and both sides sample on odd-numbered edges (1st, 3rd, ...). With CPHA set, data changes on odd edges and is sampled on even edges.
- R5: Configuration bit 13 sends the word bit 0 first. When bit 13 is clear, bit N-1 is sent first.
- R6: Configuration bit 14 places the first received bit at bit 0 of the received word. When bit 14 is clear, the first received bit goes to bit N-1. Bits 13 and 14 act independently.
- R7: Cause bit 0 reads 1 after a transfer completes. Any write to 0x10 clears it.
- R8: The receive register at 0x0C takes the received word (upper bits zero) in the same cycle the cause bit becomes visible. It holds that value until the next transfer completes.
- R9: A write to 0x08 during a transfer is ignored: the word on the line and the value read back from 0x08 are unchanged.
- R10: With delay d in timing bits [7:6], MISO is captured d+1 system clocks after the cycle in which the sampling SCLK edge appears. Tick spacing must be at least d+1 clocks.
- R11: During a transfer, SCLK changes only on tick cycles. SCLK ends a transfer at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | ADDR_W | Write byte offset |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | ADDR_W | Read byte offset |
| bus_rdata | output | 32 | Read data (combinational) |
| sclk_tick | input | 1 | One SCLK edge per asserted cycle during a transfer |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip selects |

## Verification
Each failure mode shows up at the ports within a predictable time:
- A miscounted edge counter makes SCLK stop early or late, or rest at the wrong level. This is visible on the first word.
- A wrong bit index shows up as a reversed or shifted word on the slave side or in the receive register, once the transfer ends.
- A wrong capture delay only shows against a slave whose output lags SCLK. It corrupts the received word from its second bit onward.
- A stale busy flag shows as a missing cause bit, or as a second transfer that a write during busy should not have started.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // Register byte offsets (software decodes these)
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_CFG    = 'h04;
  localparam int OFS_TX     = 'h08;
  localparam int OFS_RX     = 'h0C;
  localparam int OFS_CAUSE  = 'h10;
  localparam int OFS_TIMING = 'h18;

  // Field positions
  localparam int B_CS_EN  = 0;
  localparam int B_CS_IDX = 2;
  localparam int B_WIDE   = 5;
  localparam int B_DLY    = 6;
  localparam int B_CPOL   = 11;
  localparam int B_CPHA   = 12;
  localparam int B_TXLSB  = 13;
  localparam int B_RXLSB  = 14;

  typedef struct packed {
    logic [1:0] dly;
    logic       wide;
    logic       rx_lsb;
    logic       tx_lsb;
    logic       cpha;
    logic       cpol;
  } spim_mode_t;

  function automatic int f_word_bits(int wmax, logic wide);
    return wide ? wmax : wmax / 2;
  endfunction

  // Which bit of the word is on MOSI after a number of edges
  function automatic int f_out_index(int edges_done, logic cpha, int nbits);
    int i;
    if (cpha) i = (edges_done == 0) ? 0 : (edges_done - 1) / 2;
    else      i = edges_done / 2;
    if (i > nbits - 1) i = nbits - 1;
    return i;
  endfunction

  function automatic int f_bit_pos(int idx, int nbits, logic lsb_first);
    return lsb_first ? idx : nbits - 1 - idx;
  endfunction

  // Edge numbered from 0: even = leading, odd = trailing
  function automatic logic f_is_sample_edge(int edge_idx, logic cpha);
    return ((edge_idx % 2) == 0) != cpha;
  endfunction
endpackage

// File: rtl/spim_csdec.sv
module spim_csdec #(
  parameter int NCS = 8,
  localparam int CSW = $clog2(NCS)
) (
  input  logic           en,
  input  logic [CSW-1:0] idx,
  output logic [NCS-1:0] sel_n
);
  for (genvar g = 0; g < NCS; g++) begin : g_sel
    assign sel_n[g] = !(en && (idx == CSW'(g)));
  end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DW     = 32,
  parameter int WMAX   = 16,
  parameter int NCS    = 8,
  localparam int CSW = $clog2(NCS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              busy,
  input  logic              done,
  input  logic [WMAX-1:0]   rx_word,
  output spim_mode_t        mode,
  output logic              cs_en,
  output logic [CSW-1:0]    cs_idx,
  output logic              start,
  output logic [WMAX-1:0]   tx_word,
  output logic              cause
);
  logic hit_ctrl, hit_cfg, hit_tx, hit_cause, hit_tim;
  assign hit_ctrl  = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
  assign hit_cfg   = wr_en && (wr_addr == ADDR_W'(OFS_CFG));
  assign hit_tx    = wr_en && (wr_addr == ADDR_W'(OFS_TX));
  assign hit_cause = wr_en && (wr_addr == ADDR_W'(OFS_CAUSE));
  assign hit_tim   = wr_en && (wr_addr == ADDR_W'(OFS_TIMING));
  assign start     = hit_tx && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_en   <= 1'b0;
      cs_idx  <= '0;
      mode    <= '{dly: 2'd1, default: 1'b0};
      tx_word <= '0;
      cause   <= 1'b0;
    end else begin
      if (hit_ctrl) begin
        cs_en  <= wr_data[B_CS_EN];
        cs_idx <= wr_data[B_CS_IDX +: CSW];
      end
      if (hit_cfg) begin
        mode.cpol   <= wr_data[B_CPOL];
        mode.cpha   <= wr_data[B_CPHA];
        mode.tx_lsb <= wr_data[B_TXLSB];
        mode.rx_lsb <= wr_data[B_RXLSB];
        mode.wide   <= wr_data[B_WIDE];
      end
      if (hit_tim) mode.dly <= wr_data[B_DLY +: 2];
      if (start)   tx_word  <= wr_data[WMAX-1:0];
      if (done)           cause <= 1'b1;
      else if (hit_cause) cause <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(OFS_CTRL)) begin
      rd_data[B_CS_EN]          = cs_en;
      rd_data[B_CS_IDX +: CSW]  = cs_idx;
    end else if (rd_addr == ADDR_W'(OFS_CFG)) begin
      rd_data[B_CPOL]  = mode.cpol;
      rd_data[B_CPHA]  = mode.cpha;
      rd_data[B_TXLSB] = mode.tx_lsb;
      rd_data[B_RXLSB] = mode.rx_lsb;
      rd_data[B_WIDE]  = mode.wide;
    end else if (rd_addr == ADDR_W'(OFS_TX)) begin
      rd_data = DW'(tx_word);
    end else if (rd_addr == ADDR_W'(OFS_RX)) begin
      rd_data = DW'(rx_word);
    end else if (rd_addr == ADDR_W'(OFS_CAUSE)) begin
      rd_data[0] = cause;
    end else if (rd_addr == ADDR_W'(OFS_TIMING)) begin
      rd_data[B_DLY +: 2] = mode.dly;
    end
  end

  // R7: completion always becomes visible as a set cause bit
  p_cause_follows_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cause);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int WMAX = 16,
  localparam int CNT_W = $clog2(2 * WMAX + 1),
  localparam int BIT_W = $clog2(WMAX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            start,
  input  logic [WMAX-1:0] tx_in,
  input  spim_mode_t      mode_live,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            busy,
  output logic            done,
  output logic [WMAX-1:0] rx_word
);
  spim_mode_t       m_l;
  logic             busy_q, tg_q, pend_q;
  logic [CNT_W-1:0] cnt_q, last_edge;
  logic [BIT_W:0]   rcnt_q;
  logic [1:0]       dly_q;
  logic [WMAX-1:0]  tx_q, rsh_q, rx_q;
  int               nbits;

  assign nbits     = f_word_bits(WMAX, m_l.wide);
  assign last_edge = CNT_W'(2 * nbits);
  assign done      = busy_q && (cnt_q == last_edge) && !pend_q;
  assign busy      = busy_q;
  assign rx_word   = rx_q;
  assign sclk      = (busy_q ? m_l.cpol : mode_live.cpol) ^ tg_q;
  assign mosi      = busy_q &&
    tx_q[BIT_W'(f_bit_pos(f_out_index(int'(cnt_q), m_l.cpha, nbits), nbits, m_l.tx_lsb))];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_l    <= '0;
      busy_q <= 1'b0;
      tg_q   <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      rcnt_q <= '0;
      dly_q  <= '0;
      tx_q   <= '0;
      rsh_q  <= '0;
      rx_q   <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      m_l    <= mode_live;
      tx_q   <= tx_in;
      cnt_q  <= '0;
      tg_q   <= 1'b0;
      rcnt_q <= '0;
      pend_q <= 1'b0;
      rsh_q  <= '0;
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        rx_q   <= rsh_q;
      end else begin
        if (pend_q) begin
          if (dly_q == 2'd0) begin
            rsh_q[BIT_W'(f_bit_pos(int'(rcnt_q), nbits, m_l.rx_lsb))] <= miso;
            rcnt_q <= rcnt_q + 1'b1;
            pend_q <= 1'b0;
          end else begin
            dly_q <= dly_q - 2'd1;
          end
        end
        if (tick && (cnt_q != last_edge)) begin
          tg_q  <= ~tg_q;
          cnt_q <= cnt_q + 1'b1;
          if (f_is_sample_edge(int'(cnt_q), m_l.cpha)) begin
            pend_q <= 1'b1;
            dly_q  <= m_l.dly;
          end
        end
      end
    end
  end

  // R3: never more edges than the word needs
  p_edge_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= last_edge));
  // R8: received word only changes at completion
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rx_q));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int WMAX   = 16,
  parameter int NCS    = 8,
  localparam int CSW = $clog2(NCS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [31:0]       bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [31:0]       bus_rdata,
  input  logic              sclk_tick,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NCS-1:0]    spi_cs_n
);
  spim_mode_t      mode;
  logic            cs_en, start, busy, done, cause;
  logic [CSW-1:0]  cs_idx;
  logic [WMAX-1:0] tx_word, rx_word;

  spim_regs #(.ADDR_W(ADDR_W), .DW(32), .WMAX(WMAX), .NCS(NCS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr), .wr_addr(bus_waddr), .wr_data(bus_wdata),
    .rd_addr(bus_raddr), .rd_data(bus_rdata),
    .busy(busy), .done(done), .rx_word(rx_word),
    .mode(mode), .cs_en(cs_en), .cs_idx(cs_idx),
    .start(start), .tx_word(tx_word), .cause(cause)
  );

  spim_shifter #(.WMAX(WMAX)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(sclk_tick), .start(start),
    .tx_in(bus_wdata[WMAX-1:0]), .mode_live(mode), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .busy(busy), .done(done),
    .rx_word(rx_word)
  );

  spim_csdec #(.NCS(NCS)) u_cs (.en(cs_en), .idx(cs_idx), .sel_n(spi_cs_n));

  logic tx_hit;
  assign tx_hit = bus_wr && (bus_waddr == ADDR_W'(OFS_TX));

  // R2: at most one select active
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  // R4: idle clock sits at the configured polarity
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_sclk == mode.cpol));
  // R9: transmit word untouched by a write during a transfer
  p_tx_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hit && busy) |=> $stable(tx_word));
  // R11: no clock movement without a tick
  p_sclk_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sclk_tick && !done) |=> $stable(spi_sclk));
endmodule

// File: tb/spim_ctrl_tb.sv
`timescale 1ns/1ps
module spim_ctrl_tb;
  localparam int AW = 5;
  localparam int K  = 5;   // clocks between ticks
  localparam int HD = 10;  // slave history depth

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_waddr = '0, bus_raddr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sclk_tick = 1'b0;
  logic spi_sclk, spi_mosi, spi_miso;
  logic [7:0] spi_cs_n;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  spim_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .sclk_tick(sclk_tick), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // tick generator
  int tcnt = 0;
  always @(negedge clk) begin
    if (tcnt == K - 1) begin tcnt = 0; sclk_tick = 1'b1; end
    else begin tcnt++; sclk_tick = 1'b0; end
  end

  // behavioural slave seeing the bus through a lag of s_lag clocks
  logic hs [HD];
  logic hm [HD];
  int   s_lag = 0, s_ec = 0, s_n = 8, edges_seen = 0;
  logic s_cpha = 1'b0, lag_prev = 1'b0, raw_prev = 1'b0;
  logic [15:0] s_tx = '0, s_rx = '0;

  initial for (int i = 0; i < HD; i++) begin hs[i] = 1'b0; hm[i] = 1'b0; end

  always @(negedge clk) begin
    for (int i = HD - 1; i > 0; i--) begin hs[i] = hs[i-1]; hm[i] = hm[i-1]; end
    hs[0] = spi_sclk;
    hm[0] = spi_mosi;
    if (hs[0] != raw_prev) edges_seen++;
    raw_prev = hs[0];
    if (hs[s_lag] != lag_prev) begin
      if (((s_ec % 2) == 0) != s_cpha) s_rx = {s_rx[14:0], hm[s_lag]};
      s_ec++;
    end
    lag_prev = hs[s_lag];
  end

  always_comb begin
    int oi;
    if (s_cpha) oi = (s_ec == 0) ? -1 : (s_ec - 1) / 2;
    else        oi = s_ec / 2;
    spi_miso = (oi >= 0 && oi < s_n) ? s_tx[s_n - 1 - oi] : 1'b0;
  end

  function automatic logic [15:0] rev(logic [15:0] v, int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = v[n - 1 - i];
    return r;
  endfunction

  function automatic logic [15:0] msk(logic [15:0] v, int n);
    return (n == 16) ? v : {8'h00, v[7:0]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_raddr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic slave_reset();
    @(posedge clk);
    s_ec = 0; s_rx = '0; edges_seen = 0;
    lag_prev = hs[s_lag]; raw_prev = hs[0];
  endtask

  task automatic xfer(logic cpol, logic cpha, logic txl, logic rxl, logic wide,
                      logic [1:0] d, logic [15:0] txw, logic [15:0] sw,
                      int lag, bit expect_ok);
    logic [31:0] v, old_rx, r;
    logic [15:0] exp_rx, exp_sl;
    int n = wide ? 16 : 8;
    bit hold_bad = 0, seen = 0;
    wr('h18, 32'(d) << 6);
    wr('h04, (32'(cpol) << 11) | (32'(cpha) << 12) | (32'(txl) << 13) |
             (32'(rxl) << 14) | (32'(wide) << 5));
    wr('h10, 32'h0);
    repeat (12) @(negedge clk);
    s_lag = lag; s_cpha = cpha; s_n = n; s_tx = sw;
    slave_reset();
    @(negedge clk);
    rd('h0C, old_rx);
    wr('h08, 32'(txw));
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      rd('h10, v);
      if (v[0]) begin seen = 1; break; end
      rd('h0C, r);
      if (r != old_rx) hold_bad = 1;
    end
    rd('h0C, r);  // same cycle the cause bit is first seen
    exp_rx = rxl ? rev(sw, n) : msk(sw, n);
    exp_sl = txl ? rev(txw, n) : msk(txw, n);
    chk(seen, "R7 cause after word", 32'(seen), 32'h1);
    chk(!hold_bad, "R8 rx held until completion", 32'(hold_bad), 32'h0);
    if (expect_ok) chk(r == 32'(exp_rx), "R6/R8/R10 received word", r, 32'(exp_rx));
    else           chk(r != 32'(exp_rx), "R10 short delay misses lagging slave", r, 32'(exp_rx));
    repeat (12) @(negedge clk);
    if (lag == 0) chk(msk(s_rx, n) == exp_sl, "R5 slave saw word", 32'(s_rx), 32'(exp_sl));
    chk(edges_seen == 2 * n, "R3 edge count", 32'(edges_seen), 32'(2 * n));
    chk(spi_sclk == cpol, "R4/R11 idle level after word", 32'(spi_sclk), 32'(cpol));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, a;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd('h00, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd('h04, v); chk(v == 0, "R1 cfg reset", v, 0);
    rd('h18, v); chk(v == 32'h40, "R1 timing reset", v, 32'h40);
    rd('h10, v); chk(v == 0, "R1 cause reset", v, 0);
    rd('h0C, v); chk(v == 0, "R1 rx reset", v, 0);
    chk(spi_cs_n == 8'hFF, "R1 selects high", 32'(spi_cs_n), 32'hFF);
    chk(spi_sclk == 1'b0, "R1 sclk low", 32'(spi_sclk), 0);

    // R3 ticks while idle make no edge
    slave_reset();
    repeat (60) @(negedge clk);
    chk(edges_seen == 0, "R3 idle ticks ignored", 32'(edges_seen), 0);

    // R2 chip selects
    for (int i = 0; i < 8; i++) begin
      wr('h00, (32'(i) << 2) | 32'h1);
      chk(spi_cs_n == ~(8'h1 << i), "R2 select decode", 32'(spi_cs_n), 32'(~(8'h1 << i)));
    end
    wr('h00, 32'(5) << 2);
    chk(spi_cs_n == 8'hFF, "R2 select disabled", 32'(spi_cs_n), 32'hFF);
    wr('h00, 32'h1);

    // R4 directed modes, 8 bit, MSB first
    xfer(0, 0, 0, 0, 0, 2'd1, 16'h00C3, 16'h005A, 0, 1);
    xfer(0, 1, 0, 0, 0, 2'd1, 16'h0081, 16'h00E7, 0, 1);
    xfer(1, 0, 0, 0, 0, 2'd1, 16'h0017, 16'h0071, 0, 1);
    xfer(1, 1, 0, 0, 0, 2'd1, 16'h00F0, 16'h000F, 0, 1);
    // R5/R6 independent bit order, 16 bit
    xfer(0, 0, 1, 0, 1, 2'd0, 16'h8001, 16'h1234, 0, 1);
    xfer(1, 1, 0, 1, 1, 2'd3, 16'hBEEF, 16'h8001, 0, 1);

    // R7 clear and R8 hold
    rd('h0C, a);
    wr('h10, 32'h5);
    rd('h10, v); chk(v == 0, "R7 write clears cause", v, 0);
    repeat (30) @(negedge clk);
    rd('h0C, v); chk(v == a, "R8 rx holds after clear", v, a);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [31:0] rb = $urandom;
      xfer(rb[0], rb[1], rb[2], rb[3], rb[4], rb[6:5], 16'($urandom), 16'($urandom), 0, 1);
    end

    // R9 write during a transfer
    wr('h18, 32'h40);
    wr('h04, 32'h0);
    wr('h10, 32'h0);
    repeat (12) @(negedge clk);
    s_lag = 0; s_cpha = 0; s_n = 8; s_tx = 16'h0033;
    slave_reset();
    wr('h08, 32'h96);
    repeat (3) @(negedge clk);
    wr('h08, 32'h3C);
    rd('h08, v); chk(v == 32'h96, "R9 readback unchanged", v, 32'h96);
    for (int c = 0; c < 500; c++) begin
      @(negedge clk); rd('h10, v); if (v[0]) break;
    end
    repeat (12) @(negedge clk);
    chk(s_rx[7:0] == 8'h96, "R9 line carries first word", 32'(s_rx[7:0]), 32'h96);
    wr('h10, 32'h0);
    slave_reset();
    repeat (200) @(negedge clk);
    rd('h10, v); chk(v == 0, "R9 no second transfer", v, 0);
    chk(edges_seen == 0, "R9 no extra edges", 32'(edges_seen), 0);

    // R10 sample delay against a slave lagging 7 clocks
    xfer(0, 0, 0, 0, 0, 2'd2, 16'h0055, 16'h00A5, 7, 1);
    xfer(0, 0, 0, 0, 0, 2'd3, 16'h0055, 16'h00A5, 7, 1);
    xfer(0, 0, 0, 0, 0, 2'd1, 16'h0055, 16'h00A5, 7, 0);
    xfer(0, 0, 0, 0, 0, 2'd0, 16'h0055, 16'h00A5, 7, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule